// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two 16-bit buses, A and B. Each direction of transfer has its own level-sensitive holding latch: A-to-B and B-to-A. A direction has three active-low controls: a chip enable, a latch enable and an output enable. The chip enable gates both whether data can enter that direction's latch and whether the far port is driven. The latch is transparent while the latch enable is low. Its rising edge freezes the value that was last seen.

The 16 bits are split into two 8-bit groups. Each group has its own full set of six controls. The groups can therefore be run as two separate byte-wide transceivers, or, with their controls tied together, as one 16-bit path. Each bidirectional pin is split into an input bus, an output bus and a per-group output enable. The actual tristate buffers belong in a pad wrapper above this block. An undriven group shows output enable low and zero data. A per-group flag reports when both directions drive the same group at once.

Top module: `xcvr_latched`

## Requirements
- R1: While a group's A-to-B chip enable and latch enable are both low, that group's A-to-B latch is transparent. When the group is driven, its B output follows A input in the same settle.
- R2: A low-to-high transition of the A-to-B latch enable, with the chip enable low, freezes the latch. Later changes on A input do not reach B output.
- R3: While a group's A-to-B chip enable is high, its latch keeps its contents whatever the latch enable does, and its B output enable is low.
- R4: A group's B output enable (b_oe bit 0 = bits 7:0, bit 1 = bits 15:8) is high exactly when its A-to-B chip enable and output enable are both low. An undriven group's B output bits read zero.
- R5: The B-to-A direction behaves like R1 to R4 with its own controls, latch and A outputs. It has no dependence on the A-to-B controls.
- R6: Group 0 (bits 7:0) and group 1 (bits 15:8) are controlled only by bit 0 and bit 1 of each control bus, respectively.
- R7: conflict bit g is high exactly when a_oe bit g and b_oe bit g are both high.
- R8: An active-low asynchronous reset clears both latches of every group to zero, even while they are transparent.
- R9: Toggling an output enable leaves the latch contents unchanged. Re-enabling the output shows the value held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all latches |
| a_in | input | 16 | Data seen on port A |
| b_in | input | 16 | Data seen on port B |
| ceab_n | input | 2 | A-to-B chip enable per group, active low |
| leab_n | input | 2 | A-to-B latch enable per group, active low |
| oeab_n | input | 2 | A-to-B output enable per group, active low |
| ceba_n | input | 2 | B-to-A chip enable per group, active low |
| leba_n | input | 2 | B-to-A latch enable per group, active low |
| oeba_n | input | 2 | B-to-A output enable per group, active low |
| b_out | output | 16 | Data to drive on port B, zero when undriven |
| b_oe | output | 2 | Port B drive enable per group |
| a_out | output | 16 | Data to drive on port A, zero when undriven |
| a_oe | output | 2 | Port A drive enable per group |
| conflict | output | 2 | Both directions driving the same group |

## Verification
The only internal state is the four byte-wide latches, and a latch only becomes visible once its output enable is low. A wrongly captured or wrongly kept byte therefore stays hidden while its group is undriven. It appears on the port the moment that group is enabled again. A latch that stays open after the rising latch enable shows within one input change: B output tracks A input when it should have stayed frozen. A control wired to the wrong group shows at once, as a byte moving or going undriven in the other group.

// File: rtl/xcvr_latched.sv
module xcvr_latched #(
  parameter int GW = 8,
  parameter int NG = 2
) (
  input  logic             rst_n,
  input  logic [GW*NG-1:0] a_in,
  input  logic [GW*NG-1:0] b_in,
  input  logic [NG-1:0]    ceab_n,
  input  logic [NG-1:0]    leab_n,
  input  logic [NG-1:0]    oeab_n,
  input  logic [NG-1:0]    ceba_n,
  input  logic [NG-1:0]    leba_n,
  input  logic [NG-1:0]    oeba_n,
  output logic [GW*NG-1:0] b_out,
  output logic [NG-1:0]    b_oe,
  output logic [GW*NG-1:0] a_out,
  output logic [NG-1:0]    a_oe,
  output logic [NG-1:0]    conflict
);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GW-1:0] hold_ab;
    logic [GW-1:0] hold_ba;
    logic          open_ab;
    logic          open_ba;

    assign open_ab = ~ceab_n[g] & ~leab_n[g];
    assign open_ba = ~ceba_n[g] & ~leba_n[g];

    always_latch begin
      if (!rst_n)       hold_ab = '0;
      else if (open_ab) hold_ab = a_in[g*GW +: GW];
    end

    always_latch begin
      if (!rst_n)       hold_ba = '0;
      else if (open_ba) hold_ba = b_in[g*GW +: GW];
    end

    assign b_oe[g] = ~ceab_n[g] & ~oeab_n[g];
    assign a_oe[g] = ~ceba_n[g] & ~oeba_n[g];

    assign b_out[g*GW +: GW] = b_oe[g] ? hold_ab : '0;
    assign a_out[g*GW +: GW] = a_oe[g] ? hold_ba : '0;

    assign conflict[g] = b_oe[g] & a_oe[g];
  end

endmodule

// File: rtl/xcvr_latched_chk.sv
module xcvr_latched_chk #(
  parameter int GW = 8,
  parameter int NG = 2
) (
  input logic             rst_n,
  input logic [GW*NG-1:0] a_in,
  input logic [GW*NG-1:0] b_in,
  input logic [NG-1:0]    ceab_n,
  input logic [NG-1:0]    leab_n,
  input logic [NG-1:0]    oeab_n,
  input logic [NG-1:0]    ceba_n,
  input logic [NG-1:0]    leba_n,
  input logic [NG-1:0]    oeba_n,
  input logic [GW*NG-1:0] b_out,
  input logic [NG-1:0]    b_oe,
  input logic [GW*NG-1:0] a_out,
  input logic [NG-1:0]    a_oe,
  input logic [NG-1:0]    conflict
);

  always_comb begin
    if (!rst_n) begin
      p_cleared_r8: assert (b_out == '0 && a_out == '0);
    end
    for (int g = 0; g < NG; g++) begin
      if (rst_n) begin
        if (!ceab_n[g] && !leab_n[g] && b_oe[g])
          p_follow_ab_r1: assert (b_out[g*GW +: GW] == a_in[g*GW +: GW]);
        if (!ceba_n[g] && !leba_n[g] && a_oe[g])
          p_follow_ba_r5: assert (a_out[g*GW +: GW] == b_in[g*GW +: GW]);
        if (ceab_n[g])
          p_idle_ab_r3: assert (!b_oe[g]);
        if (!b_oe[g])
          p_quiet_b_r4: assert (b_out[g*GW +: GW] == '0);
        if (!a_oe[g])
          p_quiet_a_r5: assert (a_out[g*GW +: GW] == '0);
        p_contend_r7: assert (conflict[g] == (a_oe[g] && b_oe[g]));
      end
    end
  end

endmodule

bind xcvr_latched xcvr_latched_chk #(.GW(GW), .NG(NG)) u_chk (.*);

// File: tb/test_xcvr_latched.sv
module test_xcvr_latched;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] a_in, b_in;
  logic [1:0]  ceab_n, leab_n, oeab_n, ceba_n, leba_n, oeba_n;
  logic [15:0] b_out, a_out;
  logic [1:0]  b_oe, a_oe, conflict;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_latched i_xcvr_latched (
    .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ceab_n(ceab_n), .leab_n(leab_n), .oeab_n(oeab_n),
    .ceba_n(ceba_n), .leba_n(leba_n), .oeba_n(oeba_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
    .conflict(conflict)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic t_reset();
    rst_n = 0; a_in = 16'hFFFF; b_in = 16'hFFFF;
    ceab_n = 2'b00; leab_n = 2'b00; oeab_n = 2'b00;
    ceba_n = 2'b00; leba_n = 2'b00; oeba_n = 2'b00;
    step(); settle();
    chk("R8 b_out in reset", b_out, 16'h0000);
    chk("R8 a_out in reset", a_out, 16'h0000);
    step();
    leab_n = 2'b11; leba_n = 2'b11;
    settle();
    rst_n = 1;
    settle();
    chk("R8 b_out held zero after reset", b_out, 16'h0000);
    chk("R7 both driving", {14'd0, conflict}, 16'h0003);
    step();
    ceab_n = 2'b11; leab_n = 2'b11; oeab_n = 2'b11;
    ceba_n = 2'b11; leba_n = 2'b11; oeba_n = 2'b11;
    settle();
  endtask

  task automatic t_transparent();
    step();
    ceab_n = 2'b00; oeab_n = 2'b00; a_in = 16'hA5A5; settle();
    leab_n = 2'b00; settle();
    chk("R1 follow A5A5", b_out, 16'hA5A5);
    chk("R4 b_oe both", {14'd0, b_oe}, 16'h0003);
    a_in = 16'h3C96; settle();
    chk("R1 follow 3C96", b_out, 16'h3C96);
  endtask

  task automatic t_hold();
    step();
    a_in = 16'h1234; settle();
    leab_n = 2'b11; settle();
    a_in = 16'hFFFF; settle();
    chk("R2 frozen after rising le", b_out, 16'h1234);
  endtask

  task automatic t_chip_off();
    step();
    ceab_n = 2'b11; settle();
    leab_n = 2'b00; a_in = 16'h0F0F; settle();
    chk("R3 b_oe low with ce high", {14'd0, b_oe}, 16'h0000);
    chk("R4 undriven b reads zero", b_out, 16'h0000);
    leab_n = 2'b11; settle();
    ceab_n = 2'b00; settle();
    chk("R3 latch kept while ce high", b_out, 16'h1234);
  endtask

  task automatic t_oe_toggle();
    step();
    oeab_n = 2'b11; settle();
    chk("R4 oe high b_oe low", {14'd0, b_oe}, 16'h0000);
    chk("R4 oe high b_out zero", b_out, 16'h0000);
    a_in = 16'h5555; settle();
    oeab_n = 2'b00; settle();
    chk("R9 value back after oe toggle", b_out, 16'h1234);
  endtask

  task automatic t_b_to_a();
    step();
    b_in = 16'hBEEF; ceba_n = 2'b00; oeba_n = 2'b00; settle();
    leba_n = 2'b00; settle();
    chk("R5 a_out follows b_in", a_out, 16'hBEEF);
    chk("R5 a_oe both", {14'd0, a_oe}, 16'h0003);
    chk("R5 b direction untouched", b_out, 16'h1234);
    chk("R7 conflict both groups", {14'd0, conflict}, 16'h0003);
    leba_n = 2'b11; settle();
    b_in = 16'h0000; settle();
    chk("R5 b-to-a hold", a_out, 16'hBEEF);
    oeba_n = 2'b11; settle();
    chk("R7 conflict cleared", {14'd0, conflict}, 16'h0000);
  endtask

  task automatic t_groups();
    step();
    a_in = 16'hABCD; settle();
    leab_n = 2'b01; settle();
    chk("R6 only upper group follows", b_out, 16'hAB34);
    leab_n = 2'b11; settle();
    oeab_n = 2'b10; settle();
    chk("R6 only lower group driven", b_out, 16'h0034);
    chk("R6 b_oe lower only", {14'd0, b_oe}, 16'h0001);
    oeab_n = 2'b00; settle();
    chk("R6 upper byte kept", b_out, 16'hAB34);
  endtask

  task automatic t_contention();
    step();
    oeab_n = 2'b10; oeba_n = 2'b01; settle();
    chk("R7 no overlap", {14'd0, conflict}, 16'h0000);
    oeba_n = 2'b10; settle();
    chk("R7 lower group clash", {14'd0, conflict}, 16'h0001);
    chk("R5 a_out lower byte", a_out, 16'h00EF);
    oeba_n = 2'b11; settle();
    chk("R7 clash gone", {14'd0, conflict}, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_transparent();
    t_hold();
    t_chip_off();
    t_oe_toggle();
    t_b_to_a();
    t_groups();
    t_contention();
    step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule